// File: doc/BRIEF.md
# 8-bit Processor ALU with Status Flag Generation

This block is the purely combinational arithmetic and logic stage of an 8-bit accumulator processor core. In one evaluation it takes a 4-bit operation code, the accumulator, both index registers, one operand byte and the current status flags. It returns an 8-bit result, the merged next value of the four arithmetic flags (negative, overflow, zero, carry) and a per-flag update mask. The surrounding datapath decides where the result is written. For example, it discards the result of a compare. It also decides whether a shift or step works on the accumulator or on a memory byte, and presents that byte on the operand port.

Subtraction follows the inverted-borrow convention: a carry of 1 means no borrow occurred. The bit-test operation copies operand bits 7 and 6 straight into N and V. A special compare subtracts the operand from the AND of the accumulator and X and returns the difference as the new X. Arithmetic is always binary. The decimal-mode input is accepted and deliberately ignored.

The flag vectors on `flags_i`, `flags_o` and `upd_o` are ordered {N, V, Z, C}, bit 3 down to bit 0. For any flag whose mask bit is 0, `flags_o` passes `flags_i` through unchanged.

Top module: `alu_core`

## Requirements
- R1: Operation 0 (add) returns (A + operand + C) mod 256. C becomes bit 8 of the 9-bit sum. V is set when A and the operand share a sign bit and the result's sign bit differs from A's. The mask is 4'b1111.
- R2: Operation 1 (subtract) returns (A − operand − (1 − C)) mod 256. C becomes 1 when no borrow occurred. V is set when A's sign differs from both the operand's and the result's. The mask is 4'b1111.
- R3: Operations 2, 3 and 4 compare A, X and Y respectively against the operand. The result is the 8-bit difference. C is set when the register is greater than or equal to the operand. N and Z follow the difference. The mask is 4'b1011.
- R4: Operation 8 (bit test) returns A unchanged. It sets Z when (A AND operand) is zero, N from operand bit 7 and V from operand bit 6. The mask is 4'b1110.
- R5: Operation 9 (shift left) returns the operand shifted left with a zero entering bit 0. C takes the old bit 7. N and Z follow the result. The mask is 4'b1011.
- R6: Operation 10 (logical shift right) returns the operand shifted right with a zero entering bit 7. C takes the old bit 0. N is always 0. The mask is 4'b1011.
- R7: Operations 5 (AND with A), 6 (OR with A), 7 (XOR with A), 11 (operand + 1), 12 (operand − 1) and 14 (pass operand) update only N and Z (mask 4'b1010). Z is set when the result is zero, and N equals result bit 7.
- R8: Operation 13 returns ((A AND X) − operand) mod 256. C is set when (A AND X) is greater than or equal to the operand. N and Z follow the result. V is not updated (mask 4'b1011).
- R9: Every flag whose mask bit is 0 leaves `flags_o` equal to `flags_i`. Operation 15 (no-op) returns A with mask 4'b0000.
- R10: `dec_mode_i` has no effect on any output. Arithmetic is binary for both values of this input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Accumulator value |
| xr_i | input | 8 | X index register value |
| yr_i | input | 8 | Y index register value |
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 4 | Current flags {N,V,Z,C} |
| dec_mode_i | input | 1 | Decimal-mode flag, ignored |
| result_o | output | 8 | Operation result |
| flags_o | output | 4 | Next flags {N,V,Z,C} |
| upd_o | output | 4 | Per-flag update mask {N,V,Z,C} |

## Verification
On every evaluation, the assertions check four things. Flags outside the mask pass through unchanged. The bit-test operation copies operand bits into N and V. The right shift always clears N. Each operation class asserts exactly its own mask. The arithmetic values themselves (carry and overflow corner cases, the inverted borrow, the AND-then-subtract result, and the indifference to decimal mode) can only be shown by the bench. The bench sweeps every operation over all operand pairs with both carry-in values against an independent model, and then runs directed corner vectors.

// File: rtl/alu_pkg.sv
package alu_pkg;
    parameter int DW = 8;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMPA = 4'd2,
        OP_CMPX = 4'd3,
        OP_CMPY = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_BTST = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_ANDX = 4'd13,
        OP_PASS = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

    // flag vector layout {N,V,Z,C}
    localparam int FN = 3;
    localparam int FV = 2;
    localparam int FZ = 1;
    localparam int FC = 0;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;
    logic [W-1:0] rhs_eff;
    logic [W:0]   wide;

    always_comb begin
        rhs_eff = sub_i ? ~rhs_i : rhs_i;
        wide    = {1'b0, lhs_i} + {1'b0, rhs_eff} + {{W{1'b0}}, cin_i};
        sum_o   = wide[W-1:0];
        cout_o  = wide[W];
        ovf_o   = (lhs_i[MSB] == rhs_eff[MSB]) && (wide[MSB] != lhs_i[MSB]);
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
    parameter int W = 8
) (
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            2'd0:    res_o = lhs_i & rhs_i;
            2'd1:    res_o = lhs_i | rhs_i;
            2'd2:    res_o = lhs_i ^ rhs_i;
            default: res_o = rhs_i;
        endcase
    end
endmodule

// File: rtl/alu_shstep.sv
module alu_shstep #(
    parameter int W = 8
) (
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int MSB = W - 1;
    always_comb begin
        cout_o = 1'b0;
        unique case (sel_i)
            2'd0: begin
                res_o  = {val_i[MSB-1:0], 1'b0};
                cout_o = val_i[MSB];
            end
            2'd1: begin
                res_o  = {1'b0, val_i[MSB:1]};
                cout_o = val_i[0];
            end
            2'd2:    res_o = val_i + {{(W-1){1'b0}}, 1'b1};
            default: res_o = val_i - {{(W-1){1'b0}}, 1'b1};
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = alu_pkg::DW
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] xr_i,
    input  logic [W-1:0] yr_i,
    input  logic [W-1:0] opnd_i,
    input  logic [3:0]   flags_i,
    input  logic         dec_mode_i,
    output logic [W-1:0] result_o,
    output logic [3:0]   flags_o,
    output logic [3:0]   upd_o
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    logic [W-1:0] add_lhs, add_sum, bit_res, sh_res;
    logic         add_cin, add_sub, add_cout, add_ovf, sh_cout;
    logic [1:0]   bit_sel, sh_sel;
    logic [3:0]   fresh;
    logic         dec_unused;

    assign op         = alu_op_e'(op_i);
    assign dec_unused = dec_mode_i;

    // operand routing into shared sub-units
    always_comb begin
        add_lhs = acc_i;
        add_cin = flags_i[FC];
        add_sub = 1'b1;
        bit_sel = 2'd3;
        sh_sel  = 2'd0;
        unique case (op)
            OP_ADD:  add_sub = 1'b0;
            OP_SUB:  ;
            OP_CMPA: add_cin = 1'b1;
            OP_CMPX: begin add_lhs = xr_i; add_cin = 1'b1; end
            OP_CMPY: begin add_lhs = yr_i; add_cin = 1'b1; end
            OP_ANDX: begin add_lhs = acc_i & xr_i; add_cin = 1'b1; end
            OP_AND:  bit_sel = 2'd0;
            OP_OR:   bit_sel = 2'd1;
            OP_XOR:  bit_sel = 2'd2;
            OP_SHL:  sh_sel = 2'd0;
            OP_SHR:  sh_sel = 2'd1;
            OP_INC:  sh_sel = 2'd2;
            OP_DEC:  sh_sel = 2'd3;
            default: ;
        endcase
    end

    alu_addsub #(.W(W)) u_add (
        .lhs_i(add_lhs), .rhs_i(opnd_i), .cin_i(add_cin), .sub_i(add_sub),
        .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    alu_bitops #(.W(W)) u_bit (
        .sel_i(bit_sel), .lhs_i(acc_i), .rhs_i(opnd_i), .res_o(bit_res)
    );

    alu_shstep #(.W(W)) u_sh (
        .sel_i(sh_sel), .val_i(opnd_i), .res_o(sh_res), .cout_o(sh_cout)
    );

    // result, fresh flag values and update mask
    always_comb begin
        fresh = 4'b0000;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result_o  = add_sum;
                upd_o     = 4'b1111;
                fresh[FC] = add_cout;
                fresh[FV] = add_ovf;
            end
            OP_CMPA, OP_CMPX, OP_CMPY, OP_ANDX: begin
                result_o  = add_sum;
                upd_o     = 4'b1011;
                fresh[FC] = add_cout;
            end
            OP_AND, OP_OR, OP_XOR, OP_PASS: begin
                result_o = bit_res;
                upd_o    = 4'b1010;
            end
            OP_INC, OP_DEC: begin
                result_o = sh_res;
                upd_o    = 4'b1010;
            end
            OP_SHL, OP_SHR: begin
                result_o  = sh_res;
                upd_o     = 4'b1011;
                fresh[FC] = sh_cout;
            end
            OP_BTST: begin
                result_o = acc_i;
                upd_o    = 4'b1110;
            end
            default: begin
                result_o = acc_i;
                upd_o    = 4'b0000;
            end
        endcase
        if (op == OP_BTST) begin
            fresh[FN] = opnd_i[MSB];
            fresh[FV] = opnd_i[MSB-1];
            fresh[FZ] = ((acc_i & opnd_i) == '0);
        end else begin
            fresh[FN] = result_o[MSB];
            fresh[FZ] = (result_o == '0);
        end
        for (int i = 0; i < 4; i++)
            flags_o[i] = upd_o[i] ? fresh[i] : flags_i[i];
    end

    // checks guarding the flag merge and the per-class masks
    always_comb begin
        for (int i = 0; i < 4; i++)
            AST_KEEP_UNMASKED: assert (upd_o[i] || (flags_o[i] == flags_i[i])); // R9
        if (op == OP_BTST)
            AST_BTST_COPY: assert (flags_o[FN] == opnd_i[MSB] && flags_o[FV] == opnd_i[MSB-1]); // R4
        if (op == OP_SHR)
            AST_SHR_NEG_CLEAR: assert (flags_o[FN] == 1'b0); // R6
        if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_INC || op == OP_DEC || op == OP_PASS)
            AST_LOGIC_MASK: assert (upd_o == 4'b1010); // R7
        if (op == OP_ANDX || op == OP_CMPA)
            AST_CMP_NO_V: assert (!upd_o[FV] && upd_o[FC]); // R8
        if (op == OP_NOP)
            AST_NOP_HOLD: assert (upd_o == 4'b0000 && result_o == acc_i); // R9
    end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op;
    logic [7:0] a, x, y, b, res;
    logic [3:0] fi, fo, mk;
    logic       dm;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    always #10 clk = ~clk;

    alu_core u0 (
        .op_i(op), .acc_i(a), .xr_i(x), .yr_i(y), .opnd_i(b),
        .flags_i(fi), .dec_mode_i(dm),
        .result_o(res), .flags_o(fo), .upd_o(mk)
    );

    // {op, a, x, operand, flags_in, result, flags_out, mask}
    localparam logic [47:0] VEC [12] = '{
        {4'd0,  8'h50, 8'h00, 8'h50, 4'b0000, 8'hA0, 4'b1100, 4'b1111},
        {4'd0,  8'hFF, 8'h00, 8'h01, 4'b0000, 8'h00, 4'b0011, 4'b1111},
        {4'd1,  8'h50, 8'h00, 8'hB0, 4'b0001, 8'hA0, 4'b1100, 4'b1111},
        {4'd1,  8'h05, 8'h00, 8'h05, 4'b0000, 8'hFF, 4'b1000, 4'b1111},
        {4'd2,  8'h10, 8'h00, 8'h10, 4'b0100, 8'h00, 4'b0111, 4'b1011},
        {4'd8,  8'h0F, 8'h00, 8'hC0, 4'b0001, 8'h0F, 4'b1111, 4'b1110},
        {4'd9,  8'h00, 8'h00, 8'h81, 4'b0000, 8'h02, 4'b0001, 4'b1011},
        {4'd10, 8'h00, 8'h00, 8'h01, 4'b1000, 8'h00, 4'b0011, 4'b1011},
        {4'd13, 8'hF0, 8'h3C, 8'h31, 4'b0101, 8'hFF, 4'b1100, 4'b1011},
        {4'd12, 8'h00, 8'h00, 8'h00, 4'b0001, 8'hFF, 4'b1001, 4'b1010},
        {4'd11, 8'h00, 8'h00, 8'hFF, 4'b1000, 8'h00, 4'b0010, 4'b1010},
        {4'd15, 8'h42, 8'h00, 8'h00, 4'b1010, 8'h42, 4'b1010, 4'b0000}
    };

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0:  return "R1";
            4'd1:  return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd8:  return "R4";
            4'd9:  return "R5";
            4'd10: return "R6";
            4'd13: return "R8";
            4'd15: return "R9";
            default: return "R7";
        endcase
    endfunction

    // independent model: returns {result, flags_out, mask}
    function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] ra,
            input logic [7:0] rx, input logic [7:0] ry, input logic [7:0] rb, input logic [3:0] f);
        int ia = int'(ra), ib = int'(rb), cin = int'(f[0]), r = 0, lhs = 0;
        logic [7:0] out = ra;
        logic n = f[3], v = f[2], z = f[1], c = f[0];
        logic [3:0] m = 4'b0000;
        case (o)
            4'd0: begin r = ia + ib + cin; out = r[7:0]; c = (r > 255);
                v = (ra[7] == rb[7]) && (out[7] != ra[7]); m = 4'b1111; end
            4'd1: begin r = ia - ib - (1 - cin); out = r[7:0]; c = (r >= 0);
                v = (ra[7] != rb[7]) && (ra[7] != out[7]); m = 4'b1111; end
            4'd2, 4'd3, 4'd4, 4'd13: begin
                lhs = (o == 4'd2) ? ia : (o == 4'd3) ? int'(rx) : (o == 4'd4) ? int'(ry) : int'(ra & rx);
                r = lhs - ib; out = r[7:0]; c = (lhs >= ib); m = 4'b1011; end
            4'd5: begin out = ra & rb; m = 4'b1010; end
            4'd6: begin out = ra | rb; m = 4'b1010; end
            4'd7: begin out = ra ^ rb; m = 4'b1010; end
            4'd11: begin r = (ib + 1) % 256; out = r[7:0]; m = 4'b1010; end
            4'd12: begin r = (ib + 255) % 256; out = r[7:0]; m = 4'b1010; end
            4'd14: begin out = rb; m = 4'b1010; end
            4'd8: begin out = ra; z = ((ra & rb) == 0); n = rb[7]; v = rb[6]; m = 4'b1110; end
            4'd9: begin r = (ib * 2) % 256; out = r[7:0]; c = rb[7]; m = 4'b1011; end
            4'd10: begin r = ib / 2; out = r[7:0]; c = rb[0]; m = 4'b1011; end
            default: begin out = ra; m = 4'b0000; end
        endcase
        if (m[3] && o != 4'd8) n = out[7];
        if (m[1] && o != 4'd8) z = (out == 8'h00);
        return {out, n, v, z, c, m};
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        checks++;
        if ({res, fo, mk} !== exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%h x=%h b=%h fi=%b dm=%b: got res=%h flags=%b mask=%b, exp res=%h flags=%b mask=%b",
                     tag, op, a, x, b, fi, dm, res, fo, mk, exp[15:8], exp[7:4], exp[3:0]);
        end
    endtask

    initial begin
        op = 4'd15; a = 0; x = 0; y = 0; b = 0; fi = 0; dm = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // table walk, R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < 12; k++) begin
            {op, a, x, b, fi} = VEC[k][47:16];
            y = 8'h00; dm = 1'b0;
            #1;
            check(req_of(op), VEC[k][15:0]);
        end
        // exhaustive sweep of every operation, all operand pairs, both carries
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 256; i++)
                for (int j = 0; j < 256; j++)
                    for (int c = 0; c < 2; c++) begin
                        op = 4'(o); a = 8'(i); b = 8'(j);
                        x = a ^ 8'h5A; y = ~a + 8'(j[2:0]);
                        fi = {j[0], i[0], j[1], 1'(c)};
                        dm = i[1];   // R10: decimal flag toggled, must not matter
                        #1;
                        check(req_of(op), model(op, a, x, y, b, fi));
                    end
        // R10 directed: decimal-looking add and subtract stay binary
        op = 4'd0; a = 8'h09; b = 8'h01; fi = 4'b0000; x = 0; y = 0; dm = 1'b1;
        #1; check("R10", {8'h0A, 4'b0000, 4'b1111});
        op = 4'd1; a = 8'h10; b = 8'h01; fi = 4'b0001; dm = 1'b1;
        #1; check("R10", {8'h0F, 4'b0001, 4'b1111});
        // R3 compare of Y, and R9 no-op keeps every flag
        op = 4'd4; a = 8'h00; y = 8'h7F; b = 8'h80; fi = 4'b0100; dm = 1'b0;
        #1; check("R3", {8'hFF, 4'b1100, 4'b1011});
        op = 4'd15; a = 8'h99; fi = 4'b0101;
        #1; check("R9", {8'h99, 4'b0101, 4'b0000});
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not complete, got hang, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule